// File: doc/BRIEF.md
# DMA Channel Address Generator

This block is the parameter engine of one DMA channel. Software, or a parameter fetcher, writes an internal index, a signed modify step, a word count, a chain pointer and a general-purpose word through a small register-write port, and then sets the control bits. While the channel is enabled and its data port has work pending, the block raises a request. Each granted cycle is one transfer. In that cycle the block drives an internal memory address, which is the index plus a fixed base. It then post-modifies the index by the step and decrements the count.

When the count runs out, the block pulses an interrupt and stops. In chained mode it also raises a chain request that carries the chain pointer, so that an external fetcher can load the next parameter set. The channel resumes once that load is acknowledged. In chain-insertion mode the channel moves no data, but a write to the chain pointer raises the same chain request.

Top module: `dma_param_engine`

## Requirements
- R1: In every transfer cycle (`mem_strobe` high), `mem_addr` equals 0x0004_0000 plus the current 18-bit index.
- R2: After each transfer, the index becomes the index plus the 18-bit two's-complement modify value, so positive steps move the address up and negative steps move it down.
- R3: The index is kept modulo 2^18. A step past 0x3FFFF lands on 0 (address 0x0004_0000), and a step below 0 lands on 0x3FFFF.
- R4: The count drops by one per transfer. The transfer that takes it from 1 to 0 makes `irq` high for exactly the following cycle, and no other transfer raises `irq`.
- R5: A count loaded as 0 yields exactly 65536 transfers before `irq`.
- R6: While the enable bit (control bit 0) is clear, `dma_req` and `mem_strobe` stay low whatever `port_req` and `grant` do. Clearing the bit in the middle of a run stops the run and no `irq` follows.
- R7: Control bits take effect on the second clock edge after the write. The edge that stores the write leaves `dma_req` unchanged, and the next edge applies it.
- R8: Mode 01 (chain bit 1 clear, enable bit 0 set) is a single run. After completion, `dma_req` stays low until the enable bit is cleared and set again.
- R9: Mode 11 auto-chains. Completion raises `chain_req` with `chain_ptr` equal to the chain pointer. Both are held until `chain_ack`, and transfers resume with the parameters then present.
- R10: Mode 10 is chain insertion. No transfers happen in this mode. A chain pointer write raises `chain_req`, and `chain_ack` clears it.
- R11: After reset, `dma_req`, `mem_strobe`, `irq` and `chain_req` are low.
- R12: Register-select codes are 0 for index, 1 for modify, 2 for count, 3 for chain pointer, 4 for general purpose and 5 for control. The general-purpose word reads back on `gp_value`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | 32 | Write data |
| port_req | input | 1 | Data port has a word to move |
| grant | input | 1 | Arbiter grant for this channel |
| dma_req | output | 1 | Channel requests service |
| mem_strobe | output | 1 | Transfer happens this cycle |
| mem_addr | output | 32 | Internal memory address |
| irq | output | 1 | Completion interrupt pulse |
| chain_req | output | 1 | Next parameter block wanted |
| chain_ptr | output | 18 | Address of the next parameter block |
| chain_ack | input | 1 | Next parameter block loaded |
| gp_value | output | 32 | General-purpose register |

## Verification
A wrong index shows up on `mem_addr` in the first transfer that follows the fault, because every granted cycle exposes the index plus the base. A wrong count shows up only at the end of a run, when `irq` arrives early or late. The bench therefore counts every strobe up to the interrupt, including a full 65536-word run. A stuck finished flag or chain flag shows as `dma_req` staying low, or going high, in the cycle after the edge that should change it.

// File: rtl/dma_param_engine.sv
module dma_param_engine #(
  parameter int IDX_W  = 18,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] BASE = 32'h0004_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              port_req,
  input  logic              grant,
  output logic              dma_req,
  output logic              mem_strobe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              irq,
  output logic              chain_req,
  output logic [IDX_W-1:0]  chain_ptr,
  input  logic              chain_ack,
  output logic [DATA_W-1:0] gp_value
);
  localparam logic [2:0] SEL_IDX = 3'd0, SEL_MOD = 3'd1, SEL_CNT = 3'd2,
                         SEL_CP  = 3'd3, SEL_GP  = 3'd4, SEL_CTL = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_TOP = BASE + (ADDR_W'(1) << IDX_W);

  logic [IDX_W-1:0] idx, modv;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       ctl_q, ctl_eff;
  logic             finished, last;

  wire wr_idx = wr_en && wr_sel == SEL_IDX;
  wire wr_cnt = wr_en && wr_sel == SEL_CNT;
  wire wr_cp  = wr_en && wr_sel == SEL_CP;

  assign dma_req    = port_req && ctl_eff[0] && !finished && !chain_req;
  assign mem_strobe = dma_req && grant;
  assign mem_addr   = BASE + {{(ADDR_W-IDX_W){1'b0}}, idx};
  assign last       = mem_strobe && cnt == CNT_W'(1);

  always_ff @(posedge clk) begin
    if (wr_idx) idx <= wr_data[IDX_W-1:0];
    else if (mem_strobe) idx <= idx + modv;
    if (wr_cnt) cnt <= wr_data[CNT_W-1:0];
    else if (mem_strobe) cnt <= cnt - CNT_W'(1);
    if (wr_en && wr_sel == SEL_MOD) modv <= wr_data[IDX_W-1:0];
    if (wr_cp) chain_ptr <= wr_data[IDX_W-1:0];
    if (wr_en && wr_sel == SEL_GP) gp_value <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= 2'b00;
      ctl_eff   <= 2'b00;
      finished  <= 1'b0;
      chain_req <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (wr_en && wr_sel == SEL_CTL) ctl_q <= wr_data[1:0];
      ctl_eff <= ctl_q;
      irq     <= last;
      if (!ctl_eff[0]) finished <= 1'b0;
      else if (chain_req && chain_ack) finished <= 1'b0;
      else if (last) finished <= 1'b1;
      if (chain_req && chain_ack) chain_req <= 1'b0;
      else if (last && ctl_eff == 2'b11) chain_req <= 1'b1;
      else if (wr_cp && ctl_eff == 2'b10) chain_req <= 1'b1;
    end
  end

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_strobe) && !$past(wr_cnt) |-> cnt == $past(cnt) - CNT_W'(1)); // R4
  AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !$past(wr_cnt) |-> cnt == '0); // R4
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctl_q[0]) |-> !mem_strobe); // R6
  AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    chain_req && !chain_ack && !wr_cp |=> chain_req && $stable(chain_ptr)); // R9
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_strobe |-> mem_addr >= BASE && mem_addr < ADDR_TOP); // R3
endmodule

// File: tb/sim_dma_param_engine.sv
module sim_dma_param_engine;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, port_req = 0, grant = 0, chain_ack = 0;
  logic [2:0] wr_sel = 0;
  logic [31:0] wr_data = 0;
  logic dma_req, mem_strobe, irq, chain_req;
  logic [31:0] mem_addr, gp_value;
  logic [17:0] chain_ptr;
  int checks = 0, fails = 0;
  logic [17:0] m_idx, m_mod;

  dma_param_engine u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .port_req(port_req), .grant(grant), .dma_req(dma_req),
    .mem_strobe(mem_strobe), .mem_addr(mem_addr), .irq(irq), .chain_req(chain_req),
    .chain_ptr(chain_ptr), .chain_ack(chain_ack), .gp_value(gp_value));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] exp_addr(logic [17:0] i);
    return 32'h0004_0000 + {14'b0, i};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] s, logic [31:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(logic [17:0] i, logic [17:0] m, logic [15:0] c, logic [1:0] mode);
    wr(5, 0); idle(2);
    wr(0, {14'b0, i}); wr(1, {14'b0, m}); wr(2, {16'b0, c});
    wr(5, {30'b0, mode}); idle(1);
    m_idx = i; m_mod = m;
  endtask

  task automatic xfer(string req, bit is_last);
    port_req = 1; grant = 1; #1;
    chk(req, {31'b0, mem_strobe}, 1);
    chk("R1", mem_addr, exp_addr(m_idx));
    @(posedge clk); @(negedge clk);
    port_req = 0; grant = 0;
    m_idx = m_idx + m_mod;
    chk("R4", {31'b0, irq}, {31'b0, is_last});
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle(2); #1;
    chk("R11", {28'b0, dma_req, mem_strobe, irq, chain_req}, 0);
    rst_n = 1; idle(1);

    wr(4, 32'hCAFE_0123);
    chk("R12", gp_value, 32'hCAFE_0123);

    // R7 latency: load parameters, then enable while port_req is already high
    wr(0, 0); wr(1, 1); wr(2, 3);
    port_req = 1; wr(5, 1);
    chk("R7", {31'b0, dma_req}, 0);
    @(negedge clk);
    chk("R7", {31'b0, dma_req}, 1);
    port_req = 0; m_idx = 0; m_mod = 1;
    xfer("R2", 0); xfer("R2", 0); xfer("R2", 1);
    port_req = 1; #1;
    chk("R8", {31'b0, dma_req}, 0);
    port_req = 0;

    // R3 wrap upward and downward
    setup(18'h3FFFF, 18'h00001, 2, 2'b01);
    xfer("R3", 0); xfer("R3", 1);
    setup(18'h00000, 18'h3FFFF, 2, 2'b01);
    xfer("R3", 0); xfer("R3", 1);

    // R8 restart needs a disable/enable cycle
    wr(2, 1); port_req = 1; #1;
    chk("R8", {31'b0, dma_req}, 0);
    port_req = 0;
    setup(18'h100, 18'h3FFFC, 1, 2'b01);
    xfer("R8", 1);

    // random single runs
    for (int r = 0; r < 20; r++) begin
      logic [15:0] c;
      c = 16'($urandom_range(1, 6));
      setup(18'($urandom), 18'($urandom), c, 2'b01);
      for (int k = 1; k <= int'(c); k++) xfer("R2", k == int'(c));
    end

    // R6 disable mid-run
    setup(18'h20, 18'h2, 10, 2'b01);
    xfer("R6", 0); xfer("R6", 0);
    wr(5, 0); idle(1);
    port_req = 1; grant = 1;
    for (int k = 0; k < 5; k++) begin
      #1;
      chk("R6", {30'b0, dma_req, mem_strobe}, 0);
      @(negedge clk);
      chk("R6", {31'b0, irq}, 0);
    end
    port_req = 0; grant = 0;

    // R9 auto-chain
    setup(18'h40, 18'h4, 2, 2'b11);
    wr(3, 32'h0_1ABC);
    xfer("R9", 0); xfer("R9", 1);
    chk("R9", {31'b0, chain_req}, 1);
    chk("R9", {14'b0, chain_ptr}, 32'h1ABC);
    port_req = 1; idle(3); #1;
    chk("R9", {30'b0, chain_req, dma_req}, 2'b10);
    port_req = 0;
    wr(0, 32'h500); wr(2, 1);
    chain_ack = 1; @(negedge clk); chain_ack = 0;
    chk("R9", {31'b0, chain_req}, 0);
    m_idx = 18'h500;
    xfer("R9", 1);

    // R10 chain insertion
    setup(18'h10, 18'h1, 4, 2'b10);
    port_req = 1; grant = 1; #1;
    chk("R10", {30'b0, dma_req, mem_strobe}, 0);
    port_req = 0; grant = 0;
    @(negedge clk);
    wr(3, 32'h0_2222);
    chk("R10", {31'b0, chain_req}, 1);
    chk("R10", {14'b0, chain_ptr}, 32'h2222);
    chain_ack = 1; @(negedge clk); chain_ack = 0;
    chk("R10", {31'b0, chain_req}, 0);

    // R5 count of zero
    setup(18'h0, 18'h1, 0, 2'b01);
    begin
      int n; bit got;
      n = 0; got = 0;
      port_req = 1; grant = 1;
      for (int k = 0; k < 70000 && !got; k++) begin
        #1; if (mem_strobe) n++;
        @(negedge clk); if (irq) got = 1;
      end
      port_req = 0; grant = 0;
      chk("R5", n, 65536);
      chk("R5", {31'b0, got}, 1);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule